// File: doc/BRIEF.md
# Parallel camera sync capture

This block sits at the receiving end of a parallel camera link and runs directly on the sensor's pixel clock. On every rising edge it takes one pixel word, a frame sync and a line sync. From that it produces a framed pixel stream: a valid flag together with the pixel, and single-cycle markers for frame start, frame end, line start and line end, all derived from transitions of the two sync lines.

A pixel is accepted only while both syncs are active. Line sync transitions that arrive outside an active frame produce no markers. The active level of each sync line is set by a parameter, so sensors that drive their syncs low can be connected without external inversion.

The block also measures the picture. It holds the pixel count of the most recently completed line and the line count of the most recently completed frame. Downstream logic can read these to confirm the sensor's configured resolution.

Top module: `cam_par_capture`

## Requirements
- R1: `DATA_W` (8 or 10) sets the pixel width. When `pix_valid_o` is high, `pix_data_o` equals the `data_i` word sampled two rising edges earlier.
- R2: `pix_valid_o` is high exactly when both syncs were at their active level in the sample taken two rising edges earlier.
- R3: `sof_o` pulses for one cycle together with the first sample in which the frame sync is active after being inactive. `eof_o` pulses for one cycle with the first sample in which the frame sync is inactive after being active.
- R4: `sol_o` pulses with the first sample in which the line sync is active after being inactive, provided the frame sync is active in that sample. `eol_o` pulses with the first sample in which the line sync is inactive after being active, provided the frame sync was active in the preceding sample.
- R5: A line sync pulse that occurs while the frame sync is inactive produces no `sol_o`, no `eol_o` and no valid pixel.
- R6: `line_pix_o` takes the number of valid pixels since the last line start or frame start. It updates in the same cycle that `eol_o` is high and holds its value otherwise.
- R7: `frame_lines_o` takes the number of `eol_o` pulses since the last frame start, counting one that coincides with the frame end. It updates in the same cycle that `eof_o` is high and holds its value otherwise.
- R8: With `FSYNC_HIGH`=0 or `LSYNC_HIGH`=0, the corresponding sync is treated as active low, and all outputs match those of an active-high instance fed with the inverted sync.
- R9: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; one pixel per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, polarity set by `FSYNC_HIGH` |
| lsync_i | input | 1 | Line sync, polarity set by `LSYNC_HIGH` |
| data_i | input | DATA_W | Pixel data |
| pix_valid_o | output | 1 | Pixel qualifier |
| pix_data_o | output | DATA_W | Captured pixel |
| sof_o | output | 1 | Frame start marker |
| eof_o | output | 1 | Frame end marker |
| sol_o | output | 1 | Line start marker |
| eol_o | output | 1 | Line end marker |
| line_pix_o | output | CNT_W | Pixels in last completed line |
| frame_lines_o | output | CNT_W | Lines in last completed frame |

## Verification
Every output is due two rising edges after the input sample it reflects: one edge into the sampler and one into the output registers. Both measurement registers change on the same edge as the `eol_o` or `eof_o` marker that closes their count. The bench reference model consumes each sample on the same rising edge the design does and advances its expected outputs through an equivalent two-stage delay. All comparisons are made at the falling edge, where design outputs and expectations have both settled. Directed frames add count checks taken several cycles after the frame ends, when the counts are guaranteed to be stable.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef struct packed {
    logic valid;
    logic sof;
    logic eof;
    logic sol;
    logic eol;
  } cap_ev_t;

  function automatic logic to_active(logic raw, bit high);
    return high ? raw : ~raw;
  endfunction

endpackage

// File: rtl/cam_sync_sampler.sv
module cam_sync_sampler
  import cam_cap_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter bit FSYNC_HIGH = 1'b1,
  parameter bit LSYNC_HIGH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              lsync_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              frm_cur_o,
  output logic              frm_prv_o,
  output logic              lin_cur_o,
  output logic              lin_prv_o,
  output logic [DATA_W-1:0] data_o
);

  // syncs normalised to active-high at the first flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_cur_o <= 1'b0;
      frm_prv_o <= 1'b0;
      lin_cur_o <= 1'b0;
      lin_prv_o <= 1'b0;
      data_o    <= '0;
    end else begin
      frm_cur_o <= to_active(fsync_i, FSYNC_HIGH);
      lin_cur_o <= to_active(lsync_i, LSYNC_HIGH);
      frm_prv_o <= frm_cur_o;
      lin_prv_o <= lin_cur_o;
      data_o    <= data_i;
    end
  end

endmodule

// File: rtl/cam_edge_detect.sv
module cam_edge_detect
  import cam_cap_pkg::*;
(
  input  logic    frm_cur_i,
  input  logic    frm_prv_i,
  input  logic    lin_cur_i,
  input  logic    lin_prv_i,
  output cap_ev_t ev_o
);

  always_comb begin
    ev_o.valid = frm_cur_i & lin_cur_i;
    ev_o.sof   = frm_cur_i & ~frm_prv_i;
    ev_o.eof   = ~frm_cur_i & frm_prv_i;
    // line edges qualified by frame state on the side of the edge inside the frame
    ev_o.sol   = lin_cur_i & ~lin_prv_i & frm_cur_i;
    ev_o.eol   = ~lin_cur_i & lin_prv_i & frm_prv_i;
  end

endmodule

// File: rtl/cam_run_counter.sv
module cam_run_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_o <= '0;
    end else begin
      cnt_q <= clr_i ? CNT_W'(inc_i) : cnt_nxt;
      // capture includes an increment landing on the closing cycle
      if (cap_i) last_o <= cnt_nxt;
    end
  end

endmodule

// File: rtl/cam_par_capture.sv
module cam_par_capture
  import cam_cap_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int CNT_W      = 12,
  parameter bit FSYNC_HIGH = 1'b1,
  parameter bit LSYNC_HIGH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              lsync_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              sol_o,
  output logic              eol_o,
  output logic [CNT_W-1:0]  line_pix_o,
  output logic [CNT_W-1:0]  frame_lines_o
);

  logic              frm_cur, frm_prv, lin_cur, lin_prv;
  logic [DATA_W-1:0] data_s;
  cap_ev_t           ev;

  cam_sync_sampler #(
    .DATA_W    (DATA_W),
    .FSYNC_HIGH(FSYNC_HIGH),
    .LSYNC_HIGH(LSYNC_HIGH)
  ) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .lsync_i  (lsync_i),
    .data_i   (data_i),
    .frm_cur_o(frm_cur),
    .frm_prv_o(frm_prv),
    .lin_cur_o(lin_cur),
    .lin_prv_o(lin_prv),
    .data_o   (data_s)
  );

  cam_edge_detect u_edges (
    .frm_cur_i(frm_cur),
    .frm_prv_i(frm_prv),
    .lin_cur_i(lin_cur),
    .lin_prv_i(lin_prv),
    .ev_o     (ev)
  );

  cam_run_counter #(.CNT_W(CNT_W)) u_pix_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ev.sol | ev.sof),
    .inc_i (ev.valid),
    .cap_i (ev.eol),
    .last_o(line_pix_o)
  );

  cam_run_counter #(.CNT_W(CNT_W)) u_line_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ev.sof),
    .inc_i (ev.eol),
    .cap_i (ev.eof),
    .last_o(frame_lines_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      sof_o       <= 1'b0;
      eof_o       <= 1'b0;
      sol_o       <= 1'b0;
      eol_o       <= 1'b0;
    end else begin
      pix_valid_o <= ev.valid;
      if (ev.valid) pix_data_o <= data_s;
      sof_o <= ev.sof;
      eof_o <= ev.eof;
      sol_o <= ev.sol;
      eol_o <= ev.eol;
    end
  end

endmodule

// File: rtl/cam_par_capture_chk.sv
module cam_par_capture_chk
  import cam_cap_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int CNT_W      = 12,
  parameter bit FSYNC_HIGH = 1'b1,
  parameter bit LSYNC_HIGH = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_i,
  input logic              lsync_i,
  input logic [DATA_W-1:0] data_i,
  input logic              pix_valid_o,
  input logic [DATA_W-1:0] pix_data_o,
  input logic              sof_o,
  input logic              eof_o,
  input logic              sol_o,
  input logic              eol_o,
  input logic [CNT_W-1:0]  line_pix_o,
  input logic [CNT_W-1:0]  frame_lines_o
);

  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  a_r2_valid_tracks_syncs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (pix_valid_o == (to_active($past(fsync_i, 2), FSYNC_HIGH) &&
                                         to_active($past(lsync_i, 2), LSYNC_HIGH))));

  a_r1_data_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && pix_valid_o) |-> (pix_data_o == $past(data_i, 2)));

  a_r3_sof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  a_r3_eof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);

  a_r3_frame_marks_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sof_o && eof_o));

  a_r4_sol_with_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |-> pix_valid_o);

  a_r4_eol_after_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> (!pix_valid_o && $past(pix_valid_o)));

  a_r5_sol_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && sol_o) |-> to_active($past(fsync_i, 2), FSYNC_HIGH));

  a_r6_line_pix_on_eol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_pix_o) |-> eol_o);

  a_r7_frame_lines_on_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_lines_o) |-> eof_o);

endmodule

bind cam_par_capture cam_par_capture_chk #(
  .DATA_W    (DATA_W),
  .CNT_W     (CNT_W),
  .FSYNC_HIGH(FSYNC_HIGH),
  .LSYNC_HIGH(LSYNC_HIGH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fsync_i      (fsync_i),
  .lsync_i      (lsync_i),
  .data_i       (data_i),
  .pix_valid_o  (pix_valid_o),
  .pix_data_o   (pix_data_o),
  .sof_o        (sof_o),
  .eof_o        (eof_o),
  .sol_o        (sol_o),
  .eol_o        (eol_o),
  .line_pix_o   (line_pix_o),
  .frame_lines_o(frame_lines_o)
);

// File: tb/cam_par_capture_tb_top.sv
module cam_par_capture_tb_top;

  localparam int DW = 10;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fs = 1'b0, ls = 1'b0;
  logic [DW-1:0] din = '0;

  always #10 clk = ~clk;

  logic          v_a, sof_a, eof_a, sol_a, eol_a;
  logic [DW-1:0] d_a;
  logic [CW-1:0] lp_a, fl_a;
  logic          v_b, sof_b, eof_b, sol_b, eol_b;
  logic [DW-1:0] d_b;
  logic [CW-1:0] lp_b, fl_b;

  cam_par_capture #(.DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_i(fs), .lsync_i(ls), .data_i(din),
    .pix_valid_o(v_a), .pix_data_o(d_a), .sof_o(sof_a), .eof_o(eof_a),
    .sol_o(sol_a), .eol_o(eol_a), .line_pix_o(lp_a), .frame_lines_o(fl_a));

  // active-low twin driven with inverted syncs (R8)
  cam_par_capture #(.DATA_W(DW), .CNT_W(CW), .FSYNC_HIGH(1'b0), .LSYNC_HIGH(1'b0)) dut_lo (
    .clk_i(clk), .rst_ni(rst_ni), .fsync_i(~fs), .lsync_i(~ls), .data_i(din),
    .pix_valid_o(v_b), .pix_data_o(d_b), .sof_o(sof_b), .eof_o(eof_b),
    .sol_o(sol_b), .eol_o(eol_b), .line_pix_o(lp_b), .frame_lines_o(fl_b));

  int checks = 0, errors = 0;
  bit done = 0;
  int sol_seen = 0, eol_seen = 0, v_seen = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model: stage-1 sample, stage-2 expected outputs
  bit      cf, pf, cl, pl;
  int      cd;
  bit      e_v, e_sof, e_eof, e_sol, e_eol;
  int      e_d, e_lp, e_fl, pcnt, lcnt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cf = 0; pf = 0; cl = 0; pl = 0; cd = 0;
      e_v = 0; e_sof = 0; e_eof = 0; e_sol = 0; e_eol = 0;
      e_d = 0; e_lp = 0; e_fl = 0; pcnt = 0; lcnt = 0;
    end else begin
      e_v   = cf && cl;
      e_sof = cf && !pf;
      e_eof = !cf && pf;
      e_sol = cl && !pl && cf;
      e_eol = !cl && pl && pf;
      if (e_v) e_d = cd;
      if (e_eol) e_lp = pcnt;
      if (e_sol || e_sof) pcnt = e_v ? 1 : 0;
      else if (e_v) pcnt++;
      if (e_eof) e_fl = lcnt + (e_eol ? 1 : 0);
      if (e_sof) lcnt = 0;
      else if (e_eol) lcnt++;
      pf = cf; pl = cl;
      cf = fs; cl = ls; cd = int'(din);
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R2", "valid", int'(v_a), int'(e_v));
      if (e_v) chk("R1", "data", int'(d_a), e_d);
      chk("R3", "sof", int'(sof_a), int'(e_sof));
      chk("R3", "eof", int'(eof_a), int'(e_eof));
      chk("R4", "sol", int'(sol_a), int'(e_sol));
      chk("R4", "eol", int'(eol_a), int'(e_eol));
      chk("R6", "line_pix", int'(lp_a), e_lp % (1 << CW));
      chk("R7", "frame_lines", int'(fl_a), e_fl % (1 << CW));
      chk("R8", "low_pol_match",
          int'({v_b, sof_b, eof_b, sol_b, eol_b, lp_b, fl_b}),
          int'({v_a, sof_a, eof_a, sol_a, eol_a, lp_a, fl_a}));
      if (v_a) chk("R8", "low_pol_data", int'(d_b), int'(d_a));
      if (sol_a) sol_seen++;
      if (eol_a) eol_seen++;
      if (v_a) v_seen++;
    end
  end

  task automatic step(bit f, bit l);
    @(negedge clk);
    fs = f; ls = l; din = DW'($urandom_range(0, (1 << DW) - 1));
  endtask

  task automatic run_frame(int nl, int np, bit joint_end);
    step(1, 0);
    repeat ($urandom_range(0, 3)) step(1, 0);
    for (int i = 0; i < nl; i++) begin
      for (int j = 0; j < np; j++) step(1, 1);
      if (joint_end && i == nl - 1) break;
      repeat ($urandom_range(1, 4)) step(1, 0);
    end
    step(0, 0);
    repeat (4) step(0, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9", "reset_outputs",
        int'({v_a, sof_a, eof_a, sol_a, eol_a, d_a, lp_a, fl_a}), 0);
    rst_ni = 1'b1;
    repeat (3) step(0, 0);

    run_frame(5, 7, 0);
    chk("R7", "directed_lines", int'(fl_a), 5);
    chk("R6", "directed_pix", int'(lp_a), 7);

    // line pulses outside a frame (R5)
    sol_seen = 0; eol_seen = 0; v_seen = 0;
    repeat (3) step(0, 1);
    repeat (2) step(0, 0);
    repeat (4) step(0, 1);
    repeat (4) step(0, 0);
    chk("R5", "no_sol_outside", sol_seen, 0);
    chk("R5", "no_eol_outside", eol_seen, 0);
    chk("R5", "no_pix_outside", v_seen, 0);
    chk("R6", "pix_held", int'(lp_a), 7);

    // last line ends with the frame
    run_frame(3, 11, 1);
    chk("R7", "joint_end_lines", int'(fl_a), 3);
    chk("R6", "joint_end_pix", int'(lp_a), 11);

    // single-pixel lines
    run_frame(4, 1, 0);
    chk("R6", "one_pixel_line", int'(lp_a), 1);
    chk("R7", "one_pixel_frame", int'(fl_a), 4);

    for (int k = 0; k < 6; k++)
      run_frame($urandom_range(1, 8), $urandom_range(1, 40), bit'($urandom_range(0, 1)));

    // random sync noise
    begin
      bit f = 0;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(0, 15) == 0) f = !f;
        step(f, bit'($urandom_range(0, 2) != 0));
      end
    end
    repeat (5) step(0, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule